// File: doc/BRIEF.md
# Platform External Interrupt Controller Register File

This block gathers level-sensitive interrupt requests from a set of peripheral sources and routes them to the harts of a small multi-hart system. Every hart owns two delivery contexts. The even-numbered context drives the hart's machine-level external interrupt and the odd-numbered context drives its supervisor-level external interrupt. Software programs a priority for each source and an enable mask for each context. It then takes interrupts by reading a per-context claim register and hands them back by writing the same register.

Each context keeps its own pending bits, claimed bits and a copy of each source's priority. The copy is taken at the moment the source becomes pending. A change in a source's level goes only to the lowest-numbered context that has that source enabled. A companion selector, one per context, picks the pending and unclaimed source with the highest captured priority. The context's interrupt line is high whenever that selector reports a source.

All registers are 32 bits wide and sit on a simple request/acknowledge bus with a 24-bit byte address. Every request is answered one cycle later. Accesses that the block refuses are flagged with an error and return zero.

Top module: `pic_regfile`

## Requirements
- R1: Each cycle with `bus_req` high is answered by `bus_ack` high in the following cycle, and `bus_ack` is low in any cycle that follows a cycle without a request. `bus_rdata` and `bus_err` are valid while `bus_ack` is high. An error response always carries zero read data.
- R2: Only a `bus_size` of 2 (32-bit) is accepted. Sizes 0, 1 and 3 are refused with `bus_err` and read data zero, and they change no state: a refused claim read claims nothing, and a refused write stores nothing.
- R3: The priority of source ID n is at byte address 4*n. Addresses with n = 0 or n > NUM_SRC are refused. Writes keep only the low PRIO_W bits (4 by default, maximum 15), and reads return the stored value zero-extended.
- R4: The enable word for context c is at 0x2000 + 0x80*c. Bit b enables source b (one word when NUM_SRC < 32). Bit 0 always reads zero, and bits for IDs beyond NUM_SRC read zero. Context numbers at or above 2*NUM_HARTS are refused, and so are word indices past the last one.
- R5: The threshold of context c is at 0x200000 + 0x1000*c. It stores the low PRIO_W bits, reads them back, and has no effect on the interrupt outputs. In that window only offsets 0 (threshold) and 4 (claim) are accepted, and contexts at or above 2*NUM_HARTS are refused.
- R6: When a source level rises, the source becomes pending with a copy of its current priority. Only the lowest-numbered context that has the source enabled receives this. Later priority writes do not change the copy.
- R7: When a source level falls, the pending bit, priority copy and claimed bit of that source are cleared, again only in the lowest-numbered context that has it enabled.
- R8: When an enable bit turns on while the source level is high, the source becomes pending in that context with a priority copy. When an enable bit turns on while the level is low, nothing else changes. When an enable bit turns off, the source's pending, copy and claimed state in that context are cleared.
- R9: A claim read (offset 4) returns the pending, unclaimed source with the highest captured priority. Ties go to the lowest ID, and the read returns 0 when no such source exists. The returned source is then marked claimed in that context.
- R10: Writing an ID to the claim register clears that ID's claimed bit only if the ID is at most NUM_SRC and is enabled in that context. Any other write there changes nothing, and the write itself is acknowledged without error.
- R11: `m_ext_irq[h]` follows context 2h and `s_ext_irq[h]` follows context 2h+1. Each is high exactly when its context has a pending, unclaimed source, starting the cycle after the change that caused it.
- R12: Reset clears all priorities, enables, thresholds, levels, pending, copies and claimed bits, and holds every interrupt output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Register access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access size: 0 byte, 1 half, 2 word, 3 reserved |
| bus_addr | input | 24 | Byte address inside the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| bus_ack | output | 1 | Response strobe, one cycle after bus_req |
| bus_err | output | 1 | Access was refused, valid with bus_ack |
| src_level | input | NUM_SRC+1 | Source request levels, bit n for ID n, bit 0 ignored |
| m_ext_irq | output | NUM_HARTS | Machine external interrupt per hart |
| s_ext_irq | output | NUM_HARTS | Supervisor external interrupt per hart |

## Verification
The bench builds the block with its defaults: 31 sources and 2 harts, which gives 4 contexts and a single enable word. With this size the bench can write and read back every priority register, every enable word and every threshold, and probe the addresses just outside each window. With all 31 sources pending in one context, the claim register is drained completely, and every returned ID is checked against an order the bench computes from the programmed priorities. The sources include equal-priority pairs, so tie-breaking is covered. Two contexts that share a source exercise the rule that routes each level change to the lowest-numbered enabled context.

// File: rtl/pic_pkg.sv
`timescale 1ns/1ps
package pic_pkg;

    // Window bases and per-context strides of the register map
    localparam logic [31:0] ENA_BASE   = 32'h0000_2000;
    localparam logic [31:0] CTRL_BASE  = 32'h0020_0000;
    localparam int          ENA_SHIFT  = 7;
    localparam int          CTRL_SHIFT = 12;

    // Offsets inside a context control window
    localparam logic [31:0] OFF_THRESH = 32'd0;
    localparam logic [31:0] OFF_CLAIM  = 32'd4;

    // Access size code for a 32-bit transfer
    localparam logic [1:0]  SZ_WORD    = 2'd2;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_PRIO,
        TGT_ENABLE,
        TGT_THRESH,
        TGT_CLAIM
    } pic_tgt_e;

endpackage

// File: rtl/pic_addr_decode.sv
`timescale 1ns/1ps
module pic_addr_decode
    import pic_pkg::*;
#(
    parameter int NUM_IDS = 32,
    parameter int NCTX    = 4,
    parameter int NW      = 1,
    parameter int IDX_W   = 5,
    parameter int CTX_W   = 2,
    parameter int WORD_W  = 1
) (
    input  logic [23:0]       addr,
    input  logic [1:0]        size,
    output pic_tgt_e          tgt,
    output logic [IDX_W-1:0]  id,
    output logic [CTX_W-1:0]  ctx,
    output logic [WORD_W-1:0] word
);

    localparam logic [31:0] ENA_MASK  = (32'd1 << ENA_SHIFT) - 32'd1;
    localparam logic [31:0] CTRL_MASK = (32'd1 << CTRL_SHIFT) - 32'd1;

    logic [31:0] a32;
    logic [31:0] rel;
    logic [31:0] sel_id;
    logic [31:0] sel_ctx;
    logic [31:0] sel_word;
    logic [31:0] sel_off;

    always_comb begin
        a32      = {8'd0, addr};
        rel      = '0;
        sel_id   = '0;
        sel_ctx  = '0;
        sel_word = '0;
        sel_off  = '0;
        tgt      = TGT_NONE;
        if (size == SZ_WORD) begin
            if (a32 < ENA_BASE) begin
                sel_id = a32 >> 2;
                if (sel_id != 32'd0 && sel_id < 32'(NUM_IDS)) begin
                    tgt = TGT_PRIO;
                end
            end else if (a32 < CTRL_BASE) begin
                rel      = a32 - ENA_BASE;
                sel_ctx  = rel >> ENA_SHIFT;
                sel_word = (rel & ENA_MASK) >> 2;
                if (sel_ctx < 32'(NCTX) && sel_word < 32'(NW)) begin
                    tgt = TGT_ENABLE;
                end
            end else begin
                rel     = a32 - CTRL_BASE;
                sel_ctx = rel >> CTRL_SHIFT;
                sel_off = rel & CTRL_MASK;
                if (sel_ctx < 32'(NCTX)) begin
                    if (sel_off == OFF_THRESH) begin
                        tgt = TGT_THRESH;
                    end else if (sel_off == OFF_CLAIM) begin
                        tgt = TGT_CLAIM;
                    end
                end
            end
        end
        id   = IDX_W'(sel_id);
        ctx  = CTX_W'(sel_ctx);
        word = WORD_W'(sel_word);
    end

endmodule

// File: rtl/pic_best_pick.sv
`timescale 1ns/1ps
module pic_best_pick #(
    parameter int NUM_IDS = 32,
    parameter int PRIO_W  = 4,
    parameter int IDX_W   = 5
) (
    input  logic [NUM_IDS-1:0]             cand,
    input  logic [NUM_IDS-1:0][PRIO_W-1:0] prio,
    output logic [IDX_W-1:0]               best
);

    logic [PRIO_W-1:0] best_p;

    // Ascending scan: a later candidate wins only on a strictly higher
    // priority, so ties resolve to the lowest ID.
    always_comb begin
        best   = '0;
        best_p = '0;
        for (int i = 0; i < NUM_IDS; i++) begin
            if (cand[IDX_W'(i)] && (best == '0 || prio[IDX_W'(i)] > best_p)) begin
                best   = IDX_W'(i);
                best_p = prio[IDX_W'(i)];
            end
        end
    end

endmodule

// File: rtl/pic_regfile.sv
`timescale 1ns/1ps
module pic_regfile
    import pic_pkg::*;
#(
    parameter int NUM_SRC   = 31,
    parameter int NUM_HARTS = 2,
    parameter int PRIO_W    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_req,
    input  logic                 bus_we,
    input  logic [1:0]           bus_size,
    input  logic [23:0]          bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic                 bus_ack,
    output logic                 bus_err,
    input  logic [NUM_SRC:0]     src_level,
    output logic [NUM_HARTS-1:0] m_ext_irq,
    output logic [NUM_HARTS-1:0] s_ext_irq
);

    localparam int NUM_IDS = NUM_SRC + 1;
    localparam int NCTX    = 2 * NUM_HARTS;
    localparam int NW      = (NUM_IDS + 31) / 32;
    localparam int IDX_W   = $clog2(NUM_IDS);
    localparam int CTX_W   = $clog2(NCTX);
    localparam int WORD_W  = (NW > 1) ? $clog2(NW) : 1;

    typedef struct packed {
        logic [NUM_IDS-1:0][PRIO_W-1:0]            prio;
        logic [NCTX-1:0][NW-1:0][31:0]             en;
        logic [NCTX-1:0][NUM_IDS-1:0]              pend;
        logic [NCTX-1:0][NUM_IDS-1:0][PRIO_W-1:0]  snap;
        logic [NCTX-1:0][NUM_IDS-1:0]              clm;
        logic [NCTX-1:0][PRIO_W-1:0]               thr;
        logic [NUM_IDS-1:0]                        lvl;
        logic                                      ack;
        logic                                      err;
        logic [31:0]                               rdata;
    } pic_state_t;

    pic_state_t q, d;

    pic_tgt_e                     dec_tgt;
    logic [IDX_W-1:0]             dec_id;
    logic [CTX_W-1:0]             dec_ctx;
    logic [WORD_W-1:0]            dec_word;
    logic [NCTX-1:0][IDX_W-1:0]   best_id;

    logic [31:0]       wr_mask;
    logic [31:0]       new_word;
    logic [IDX_W-1:0]  done_id;
    logic              taken;

    pic_addr_decode #(
        .NUM_IDS (NUM_IDS),
        .NCTX    (NCTX),
        .NW      (NW),
        .IDX_W   (IDX_W),
        .CTX_W   (CTX_W),
        .WORD_W  (WORD_W)
    ) u_dec (
        .addr (bus_addr),
        .size (bus_size),
        .tgt  (dec_tgt),
        .id   (dec_id),
        .ctx  (dec_ctx),
        .word (dec_word)
    );

    // One selector per context over its pending, unclaimed sources
    for (genvar c = 0; c < NCTX; c++) begin : g_pick
        pic_best_pick #(
            .NUM_IDS (NUM_IDS),
            .PRIO_W  (PRIO_W),
            .IDX_W   (IDX_W)
        ) u_pick (
            .cand (q.pend[c] & ~q.clm[c]),
            .prio (q.snap[c]),
            .best (best_id[c])
        );
    end

    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_out
        assign m_ext_irq[h] = |best_id[2*h];
        assign s_ext_irq[h] = |best_id[2*h+1];
    end

    assign bus_rdata = q.rdata;
    assign bus_ack   = q.ack;
    assign bus_err   = q.err;

    always_comb begin
        d        = q;
        d.ack    = bus_req;
        d.err    = 1'b0;
        d.rdata  = '0;
        wr_mask  = '0;
        new_word = '0;
        done_id  = '0;
        taken    = 1'b0;

        // Register access
        if (bus_req) begin
            case (dec_tgt)
                TGT_PRIO: begin
                    if (bus_we) begin
                        d.prio[dec_id] = bus_wdata[PRIO_W-1:0];
                    end else begin
                        d.rdata = 32'(q.prio[dec_id]);
                    end
                end
                TGT_ENABLE: begin
                    if (!bus_we) begin
                        d.rdata = q.en[dec_ctx][dec_word];
                    end else begin
                        for (int b = 0; b < 32; b++) begin
                            wr_mask[5'(b)] = (int'(dec_word) * 32 + b != 0) &&
                                             (int'(dec_word) * 32 + b < NUM_IDS);
                        end
                        new_word = bus_wdata & wr_mask;
                        d.en[dec_ctx][dec_word] = new_word;
                        for (int i = 0; i < NUM_IDS; i++) begin
                            if (WORD_W'(i / 32) == dec_word) begin
                                if (new_word[5'(i % 32)] && !q.en[dec_ctx][dec_word][5'(i % 32)]
                                    && q.lvl[IDX_W'(i)]) begin
                                    d.pend[dec_ctx][IDX_W'(i)] = 1'b1;
                                    d.snap[dec_ctx][IDX_W'(i)] = q.prio[IDX_W'(i)];
                                end else if (!new_word[5'(i % 32)] &&
                                             q.en[dec_ctx][dec_word][5'(i % 32)]) begin
                                    d.pend[dec_ctx][IDX_W'(i)] = 1'b0;
                                    d.snap[dec_ctx][IDX_W'(i)] = '0;
                                    d.clm[dec_ctx][IDX_W'(i)]  = 1'b0;
                                end
                            end
                        end
                    end
                end
                TGT_THRESH: begin
                    if (bus_we) begin
                        d.thr[dec_ctx] = bus_wdata[PRIO_W-1:0];
                    end else begin
                        d.rdata = 32'(q.thr[dec_ctx]);
                    end
                end
                TGT_CLAIM: begin
                    if (!bus_we) begin
                        d.rdata = 32'(best_id[dec_ctx]);
                        if (best_id[dec_ctx] != '0) begin
                            d.clm[dec_ctx][best_id[dec_ctx]] = 1'b1;
                        end
                    end else if (bus_wdata < 32'(NUM_IDS)) begin
                        done_id = IDX_W'(bus_wdata);
                        if (q.en[dec_ctx][WORD_W'(bus_wdata >> 5)][bus_wdata[4:0]]) begin
                            d.clm[dec_ctx][done_id] = 1'b0;
                        end
                    end
                end
                default: begin
                    d.err = 1'b1;
                end
            endcase
        end

        // Source level changes, applied after the register access
        for (int i = 0; i < NUM_IDS; i++) begin
            if (i != 0 && src_level[IDX_W'(i)] != q.lvl[IDX_W'(i)]) begin
                d.lvl[IDX_W'(i)] = src_level[IDX_W'(i)];
                taken = 1'b0;
                for (int c = 0; c < NCTX; c++) begin
                    if (!taken && d.en[CTX_W'(c)][WORD_W'(i / 32)][5'(i % 32)]) begin
                        taken = 1'b1;
                        if (src_level[IDX_W'(i)]) begin
                            d.pend[CTX_W'(c)][IDX_W'(i)] = 1'b1;
                            d.snap[CTX_W'(c)][IDX_W'(i)] = d.prio[IDX_W'(i)];
                        end else begin
                            d.pend[CTX_W'(c)][IDX_W'(i)] = 1'b0;
                            d.snap[CTX_W'(c)][IDX_W'(i)] = '0;
                            d.clm[CTX_W'(c)][IDX_W'(i)]  = 1'b0;
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/pic_regfile_chk.sv
`timescale 1ns/1ps
module pic_regfile_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_req,
    input logic [1:0]  bus_size,
    input logic [23:0] bus_addr,
    input logic [31:0] bus_rdata,
    input logic        bus_ack,
    input logic        bus_err
);

    assert_ack_follows_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |=> bus_ack);

    assert_no_spurious_ack_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req |=> !bus_ack);

    assert_err_zero_data_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (bus_ack && bus_rdata == 32'd0));

    assert_size_refused_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_size != 2'd2) |=> bus_err);

    assert_id_zero_refused_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_addr < 24'd4) |=> bus_err);

endmodule

bind pic_regfile pic_regfile_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_size  (bus_size),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .bus_ack   (bus_ack),
    .bus_err   (bus_err)
);

// File: tb/sim_pic_regfile.sv
`timescale 1ns/1ps
module sim_pic_regfile;

    localparam int NSRC = 31;
    localparam int NH   = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [1:0]  size = 2'd2;
    logic [23:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        ack;
    logic        err;
    logic [NSRC:0] lvl = '0;
    logic [NH-1:0] m_irq;
    logic [NH-1:0] s_irq;

    int n_tests = 0;
    int n_fail  = 0;
    int pr_m [32];

    always #2.5 clk = ~clk;

    pic_regfile u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_req   (req),
        .bus_we    (we),
        .bus_size  (size),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .bus_ack   (ack),
        .bus_err   (err),
        .src_level (lvl),
        .m_ext_irq (m_irq),
        .s_ext_irq (s_irq)
    );

    function automatic int pval(int id);
        return (id * 7 + 3) % 16;
    endfunction

    function automatic logic [23:0] a_prio(int id);
        return 24'(id * 4);
    endfunction
    function automatic logic [23:0] a_en(int c);
        return 24'(32'h2000 + c * 32'h80);
    endfunction
    function automatic logic [23:0] a_thr(int c);
        return 24'(32'h20_0000 + c * 32'h1000);
    endfunction
    function automatic logic [23:0] a_clm(int c);
        return 24'(32'h20_0004 + c * 32'h1000);
    endfunction

    // Expected claim: highest captured priority, ties to the lowest ID
    function automatic int pick(logic [31:0] cand);
        int best = 0;
        int bp   = -1;
        for (int i = 1; i < 32; i++) begin
            if (cand[i] && pr_m[i] > bp) begin
                best = i;
                bp   = pr_m[i];
            end
        end
        return best;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic w, input logic [1:0] sz, input logic [23:0] a,
                        input logic [31:0] dw, output logic [31:0] dr, output logic e);
        @(negedge clk);
        req = 1'b1; we = w; size = sz; addr = a; wdata = dw;
        @(negedge clk);
        req = 1'b0; we = 1'b0;
        chk("R1 ack", {31'd0, ack}, 32'd1);
        dr = rdata;
        e  = err;
    endtask

    task automatic wr(input logic [23:0] a, input logic [31:0] dw);
        logic [31:0] r;
        logic e;
        xfer(1'b1, 2'd2, a, dw, r, e);
    endtask

    task automatic rd(input logic [23:0] a, output logic [31:0] r, output logic e);
        xfer(1'b0, 2'd2, a, 32'd0, r, e);
    endtask

    task automatic set_lvl(input logic [NSRC:0] v);
        @(negedge clk);
        lvl = v;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic        e;
        logic [31:0] cand;
        int          exp_id;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: reset state
        chk("R12 m_irq", {30'd0, m_irq}, 32'd0);
        chk("R12 s_irq", {30'd0, s_irq}, 32'd0);
        chk("R12 ack idle", {31'd0, ack}, 32'd0);
        rd(a_prio(1), r, e);   chk("R12 prio", r, 32'd0);
        rd(a_thr(3), r, e);    chk("R12 thr", r, 32'd0);
        rd(a_en(2), r, e);     chk("R12 enable", r, 32'd0);

        // R3: priority sweep, writes masked to 4 bits, IDs 0 and >31 refused
        for (int id = 0; id < 34; id++) begin
            xfer(1'b1, 2'd2, a_prio(id), 32'hFFFF_FFF0 | 32'(pval(id)), r, e);
            chk("R3 write err", {31'd0, e}, (id == 0 || id > NSRC) ? 32'd1 : 32'd0);
        end
        for (int id = 0; id < 34; id++) begin
            rd(a_prio(id), r, e);
            if (id == 0 || id > NSRC) begin
                chk("R3 refused err", {31'd0, e}, 32'd1);
                chk("R3 refused data", r, 32'd0);
            end else begin
                chk("R3 readback", r, 32'(pval(id)));
                chk("R3 read err", {31'd0, e}, 32'd0);
            end
        end
        for (int id = 1; id < 32; id++) pr_m[id] = pval(id);

        // R2: non-word sizes refused without side effect
        for (int s = 0; s < 4; s++) begin
            if (s != 2) begin
                xfer(1'b1, 2'(s), a_prio(1), 32'd0, r, e);
                chk("R2 size err", {31'd0, e}, 32'd1);
                xfer(1'b0, 2'(s), a_prio(1), 32'd0, r, e);
                chk("R2 size read data", r, 32'd0);
            end
        end
        rd(a_prio(1), r, e);   chk("R2 prio unchanged", r, 32'(pval(1)));

        // R4: enable words, bit 0 forced low, bad context/word refused
        for (int c = 0; c < 5; c++) begin
            xfer(1'b1, 2'd2, a_en(c), 32'hFFFF_FFFF, r, e);
            chk("R4 write err", {31'd0, e}, (c == 4) ? 32'd1 : 32'd0);
            if (c < 4) begin
                rd(a_en(c), r, e); chk("R4 readback", r, 32'hFFFF_FFFE);
            end
        end
        xfer(1'b0, 2'd2, 24'h002004, 32'd0, r, e);
        chk("R4 word1 refused", {31'd0, e}, 32'd1);
        for (int c = 0; c < 4; c++) wr(a_en(c), 32'd0);

        // R5: thresholds and the rest of the control window
        for (int c = 0; c < 4; c++) begin
            wr(a_thr(c), 32'h1F + 32'(c));
            rd(a_thr(c), r, e); chk("R5 thr readback", r, (32'h1F + 32'(c)) & 32'hF);
        end
        xfer(1'b0, 2'd2, 24'h200008, 32'd0, r, e);
        chk("R5 offset 8 refused", {31'd0, e}, 32'd1);
        xfer(1'b0, 2'd2, a_thr(4), 32'd0, r, e);
        chk("R5 ctx 4 refused", {31'd0, e}, 32'd1);
        for (int c = 0; c < 4; c++) wr(a_thr(c), 32'd0);

        // R9/R11: all sources in context 0, drain in computed order
        wr(a_en(0), 32'hFFFF_FFFF);
        set_lvl('1);
        chk("R11 m0 high", {31'd0, m_irq[0]}, 32'd1);
        chk("R6 only ctx0 m1", {31'd0, m_irq[1]}, 32'd0);
        chk("R6 only ctx0 s", {30'd0, s_irq}, 32'd0);
        cand = 32'hFFFF_FFFE;
        for (int k = 0; k < NSRC; k++) begin
            exp_id = pick(cand);
            rd(a_clm(0), r, e);
            chk("R9 claim order", r, 32'(exp_id));
            cand[exp_id] = 1'b0;
        end
        rd(a_clm(0), r, e);    chk("R9 empty claim", r, 32'd0);
        chk("R11 m0 low when all claimed", {31'd0, m_irq[0]}, 32'd0);

        // R10: completion rules
        wr(a_clm(0), 32'd40);
        rd(a_clm(0), r, e);    chk("R10 out-of-range ignored", r, 32'd0);
        wr(a_clm(1), 32'd5);
        rd(a_clm(0), r, e);    chk("R10 other ctx ignored", r, 32'd0);
        xfer(1'b1, 2'd2, a_clm(0), 32'd5, r, e);
        chk("R10 complete no err", {31'd0, e}, 32'd0);
        chk("R11 m0 after complete", {31'd0, m_irq[0]}, 32'd1);
        rd(a_clm(0), r, e);    chk("R10 reclaim", r, 32'd5);

        // R6: captured priority survives a later priority write
        wr(a_prio(5), 32'd15);
        wr(a_clm(0), 32'd5);
        wr(a_clm(0), 32'd12);
        exp_id = (pval(12) > pval(5)) ? 12 : 5;
        rd(a_clm(0), r, e);    chk("R6 snapshot order", r, 32'(exp_id));
        rd(a_clm(0), r, e);    chk("R6 snapshot second", r, (exp_id == 12) ? 32'd5 : 32'd12);

        // R7: fall clears pending and claimed
        set_lvl(lvl & ~(32'd1 << 12));
        wr(a_clm(0), 32'd12);
        rd(a_clm(0), r, e);    chk("R7 pending cleared", r, 32'd0);
        set_lvl(lvl | (32'd1 << 12));
        chk("R7 m0 re-raised", {31'd0, m_irq[0]}, 32'd1);
        rd(a_clm(0), r, e);    chk("R7 claimable again", r, 32'd12);

        // R6: routing to the lowest enabled context
        set_lvl('0);
        wr(a_en(0), 32'd0);
        wr(a_en(1), 32'h0000_0008);
        wr(a_en(3), 32'h0000_0018);
        set_lvl(32'h0000_0018);
        chk("R11 s0 from ctx1", {31'd0, s_irq[0]}, 32'd1);
        chk("R11 s1 from ctx3", {31'd0, s_irq[1]}, 32'd1);
        chk("R11 m low", {30'd0, m_irq}, 32'd0);
        rd(a_clm(3), r, e);    chk("R6 ctx3 gets only id4", r, 32'd4);
        rd(a_clm(3), r, e);    chk("R6 ctx3 empty", r, 32'd0);
        chk("R11 s1 low", {31'd0, s_irq[1]}, 32'd0);
        rd(a_clm(1), r, e);    chk("R6 ctx1 gets id3", r, 32'd3);

        // R8: enable transitions
        wr(a_en(2), 32'h0000_0008);
        chk("R8 enable-on pends", {31'd0, m_irq[1]}, 32'd1);
        rd(a_clm(2), r, e);    chk("R8 ctx2 claim", r, 32'd3);
        wr(a_en(1), 32'd0);
        wr(a_en(1), 32'h0000_0008);
        chk("R8 re-enable pends", {31'd0, s_irq[0]}, 32'd1);
        rd(a_clm(1), r, e);    chk("R8 claimed cleared", r, 32'd3);
        wr(a_clm(2), 32'd3);
        chk("R8 ctx2 pending again", {31'd0, m_irq[1]}, 32'd1);
        wr(a_en(2), 32'd0);
        chk("R8 disable clears", {31'd0, m_irq[1]}, 32'd0);
        wr(a_en(0), 32'h0000_0200);
        chk("R8 enable with low level", {31'd0, m_irq[0]}, 32'd0);

        // R5: threshold leaves outputs alone
        wr(a_clm(1), 32'd3);
        wr(a_thr(1), 32'd15);
        chk("R5 thr no gating", {31'd0, s_irq[0]}, 32'd1);

        // R2: refused claim read claims nothing
        xfer(1'b0, 2'd0, a_clm(1), 32'd0, r, e);
        chk("R2 claim size err", {31'd0, e}, 32'd1);
        chk("R2 claim size data", r, 32'd0);
        chk("R2 s0 still high", {31'd0, s_irq[0]}, 32'd1);
        rd(a_clm(1), r, e);    chk("R2 claim intact", r, 32'd3);

        // R12: reset in mid-run
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 outputs after reset", {28'd0, m_irq, s_irq}, 32'd0);
        rd(a_prio(5), r, e);   chk("R12 prio cleared", r, 32'd0);
        rd(a_en(1), r, e);     chk("R12 enable cleared", r, 32'd0);
        rd(a_clm(1), r, e);    chk("R12 nothing pending", r, 32'd0);

        summary();
        $finish;
    end

endmodule